// File: doc/BRIEF.md
# Serial EEPROM Burst Word Reader

This block is the host side of a three-wire serial EEPROM link (chip select, serial clock, data toward the memory) plus the memory's data return line. A single go pulse with a start address and a word count makes it fetch that many consecutive 16-bit words. Each word is fetched by a complete, independent read transaction. The chip select is first raised for one full serial clock period. Then the start bit and the two-bit read opcode are shifted out, followed by the word address, most significant bit first. Seventeen read clocks follow. The first returned bit is a dummy zero and is dropped. The remaining sixteen bits form the word, most significant bit first. Chip select is then released for one more clock period before the next word begins.

Each word appears on the parallel side as a one-cycle valid pulse together with its data. A one-cycle done pulse marks the end of the run. The serial clock high and low times and the chip-select setup time are given in nanoseconds together with the system clock period, and are converted to cycle counts at elaboration. When the optional ready input is enabled, every serial clock phase can be stretched past its minimum length until ready is seen high, up to a bounded number of extra cycles.

Top module: `mw_burst_reader`

## Requirements
- R1: After go with a nonzero count, every word's transaction begins with `ee_cs_o` rising while `ee_sk_o` is low. Chip select then stays high for one complete serial clock period (one low phase, then one high phase), with `ee_do_o` at 0, before the first command bit.
- R2: The next three serial clock periods carry the bits 1, 1, 0 on `ee_do_o` (the start bit, then read opcode 10). They are followed by ADDR_W address bits, most significant bit first, one bit per period.
- R3: The read window lasts 17 serial clock periods. `ee_di_i` is sampled in the last system cycle of each low phase. The first sample is discarded, and the other 16 samples form `word_data_o` in order from bit 15 down to bit 0.
- R4: After the read window, `ee_cs_o` is low for one serial clock period, during which `ee_sk_o` still pulses once. Words are read from addresses start, start+1, and so on, modulo 2^ADDR_W, and exactly `word_count_i` words are delivered.
- R5: Each low phase of `ee_sk_o` lasts at least ceil(SK_LOW_NS/period) system cycles and each high phase at least ceil(SK_HIGH_NS/period) cycles. With ready disabled, the phases last exactly these lengths.
- R6: With USE_RDY set, a phase that has reached its minimum length ends in the first cycle in which `ee_rdy_i` is sampled high. If ready never comes, the phase ends after RDY_POLLS further cycles.
- R7: While `ee_sk_o` stays high, `ee_do_o` and `ee_cs_o` hold their values. Both change only in cycles where `ee_sk_o` is low.
- R8: A go pulse arriving while a run is in progress is ignored. The current run continues with its original address and count.
- R9: A go with a count of 0 gives `done_o` in the next cycle and leaves `ee_cs_o`, `ee_sk_o` and `ee_do_o` low.
- R10: `word_valid_o` is a one-cycle pulse in the cycle after the final read sample of a word, while chip select and the serial clock are high. `word_data_o` holds that word in the same cycle.
- R11: `done_o` is a one-cycle pulse in the cycle after the high phase of the last word's release period ends. From then on, chip select and the serial clock are low.
- R12: During and right after reset, `ee_cs_o`, `ee_sk_o`, `ee_do_o`, `word_valid_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Start a burst (taken only when idle) |
| start_addr_i | input | ADDR_W | First word address |
| word_count_i | input | ADDR_W+1 | Number of words to read |
| word_valid_o | output | 1 | One-cycle strobe per delivered word |
| word_data_o | output | 16 | Delivered word |
| done_o | output | 1 | One-cycle strobe at the end of the burst |
| ee_cs_o | output | 1 | Chip select to the EEPROM |
| ee_sk_o | output | 1 | Serial clock to the EEPROM |
| ee_do_o | output | 1 | Serial data toward the EEPROM |
| ee_di_i | input | 1 | Serial data returned by the EEPROM |
| ee_rdy_i | input | 1 | Phase-complete handshake (used when USE_RDY is set) |

## Verification
The properties take for granted that `ee_di_i` and `ee_rdy_i` are already synchronous to `clk_i` and that the word count never exceeds 2^ADDR_W. Without these, the phase-length bounds and the hold of the serial pins across a high phase would have no defined meaning. The stimulus drives every input a few nanoseconds after the rising edge. A memory model in the bench responds only to the serial pins it observes. Ready is held always high, driven from a pseudo-random sequence, or held low so that the timeout path sets every phase length.

// File: rtl/mw_rd_pkg.sv
package mw_rd_pkg;

   localparam int WORD_W = 16;
   localparam int READ_CLKS = WORD_W + 1;

   // start bit followed by the two-bit read opcode, sent left to right
   localparam logic [2:0] RD_CMD = 3'b110;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_state_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
   parameter int LO_CYC    = 13,
   parameter int HI_CYC    = 38,
   parameter bit USE_RDY   = 1'b0,
   parameter int RDY_POLLS = 1000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic high_i,
   input  logic rdy_i,
   output logic phase_end_o
);

   localparam int MAX_MIN = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
   localparam int LIMIT   = MAX_MIN + (USE_RDY ? RDY_POLLS : 0);
   localparam int CW      = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] min_m1;
   logic          at_min;
   logic          release_ok;

   assign min_m1 = high_i ? CW'(HI_CYC - 1) : CW'(LO_CYC - 1);
   assign at_min = (cnt_q >= min_m1);

   generate
      if (USE_RDY) begin : g_rdy
         logic [CW-1:0] tmo_lim;
         assign tmo_lim    = min_m1 + CW'(RDY_POLLS);
         assign release_ok = rdy_i || (cnt_q >= tmo_lim);
      end else begin : g_fixed
         assign release_ok = rdy_i | 1'b1;
      end
   endgenerate

   assign phase_end_o = run_i && at_min && release_ok;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!run_i || phase_end_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

endmodule

// File: rtl/mw_seq.sv
module mw_seq
   import mw_rd_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = ADDR_W + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              go_i,
   input  logic [ADDR_W-1:0] start_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              phase_end_i,
   output logic              run_o,
   output logic              high_o,
   output logic              cs_o,
   output logic              sk_o,
   output logic              do_o,
   output logic              sample_o,
   output logic              last_o,
   output logic              done_o
);

   // one select period, three command bits, address, read window, release
   localparam int SLOTS = 1 + 3 + ADDR_W + READ_CLKS + 1;
   localparam int SW    = $clog2(SLOTS);
   localparam logic [SW-1:0] S_CMD0  = SW'(1);
   localparam logic [SW-1:0] S_CMDN  = SW'(3);
   localparam logic [SW-1:0] S_ADDR0 = SW'(4);
   localparam logic [SW-1:0] S_RD0   = SW'(4 + ADDR_W);
   localparam logic [SW-1:0] S_RDN   = SW'(4 + ADDR_W + READ_CLKS - 1);
   localparam logic [SW-1:0] S_REL   = SW'(SLOTS - 1);

   run_state_e        state_q;
   logic [SW-1:0]     slot_q;
   logic              high_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;
   logic              done_q;

   logic              run;
   logic              in_read;
   logic [2:0]        cmd_sh;
   logic [ADDR_W-1:0] addr_sh;

   assign run     = (state_q == ST_RUN);
   assign in_read = (slot_q >= S_RD0) && (slot_q <= S_RDN);
   assign cmd_sh  = RD_CMD << (slot_q - S_CMD0);
   assign addr_sh = addr_q << (slot_q - S_ADDR0);

   always_comb begin
      do_o = 1'b0;
      if (run && slot_q >= S_CMD0 && slot_q <= S_CMDN) begin
         do_o = cmd_sh[2];
      end else if (run && slot_q >= S_ADDR0 && slot_q < S_RD0) begin
         do_o = addr_sh[ADDR_W-1];
      end
   end

   assign run_o    = run;
   assign high_o   = high_q;
   assign cs_o     = run && (slot_q != S_REL);
   assign sk_o     = run && high_q;
   assign sample_o = run && !high_q && phase_end_i && in_read;
   assign last_o   = sample_o && (slot_q == S_RDN);
   assign done_o   = done_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         slot_q  <= '0;
         high_q  <= 1'b0;
         addr_q  <= '0;
         left_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (go_i) begin
                  if (count_i == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     state_q <= ST_RUN;
                     slot_q  <= '0;
                     high_q  <= 1'b0;
                     addr_q  <= start_i;
                     left_q  <= count_i;
                  end
               end
            end
            ST_RUN: begin
               if (phase_end_i) begin
                  high_q <= !high_q;
                  if (high_q) begin
                     if (slot_q == S_REL) begin
                        slot_q <= '0;
                        if (left_q == CNT_W'(1)) begin
                           state_q <= ST_IDLE;
                           done_q  <= 1'b1;
                        end else begin
                           left_q <= left_q - CNT_W'(1);
                           addr_q <= addr_q + ADDR_W'(1);
                        end
                     end else begin
                        slot_q <= slot_q + SW'(1);
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift
   import mw_rd_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sample_i,
   input  logic              last_i,
   input  logic              di_i,
   output logic              valid_o,
   output logic [WORD_W-1:0] data_o
);

   // the dummy leading bit leaves the top of this register unseen
   logic [WORD_W-2:0] sh_q;
   logic              valid_q;
   logic [WORD_W-1:0] data_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sh_q    <= '0;
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= sample_i && last_i;
         if (sample_i) begin
            sh_q <= {sh_q[WORD_W-3:0], di_i};
         end
         if (sample_i && last_i) begin
            data_q <= {sh_q, di_i};
         end
      end
   end

   assign valid_o = valid_q;
   assign data_o  = data_q;

endmodule

// File: rtl/mw_burst_reader.sv
module mw_burst_reader
   import mw_rd_pkg::*;
#(
   parameter int ADDR_W        = 6,
   parameter int CLK_PERIOD_PS = 20000,
   parameter int SK_HIGH_NS    = 750,
   parameter int SK_LOW_NS     = 250,
   parameter int CS_SETUP_NS   = 1000,
   parameter bit USE_RDY       = 1'b0,
   parameter int RDY_POLLS     = 1000
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                go_i,
   input  logic [ADDR_W-1:0]   start_addr_i,
   input  logic [ADDR_W:0]     word_count_i,
   output logic                word_valid_o,
   output logic [WORD_W-1:0]   word_data_o,
   output logic                done_o,
   output logic                ee_cs_o,
   output logic                ee_sk_o,
   output logic                ee_do_o,
   input  logic                ee_di_i,
   input  logic                ee_rdy_i
);

   localparam int CNT_W  = ADDR_W + 1;
   localparam int HI_CYC = ceil_div(SK_HIGH_NS * 1000, CLK_PERIOD_PS);
   localparam int LO_CYC = ceil_div(SK_LOW_NS * 1000, CLK_PERIOD_PS);
   localparam int CS_CYC = ceil_div(CS_SETUP_NS * 1000, CLK_PERIOD_PS);

   generate
      if (!(ADDR_W == 6 || ADDR_W == 8)) begin : g_bad_addr_w
         $error("mw_burst_reader: ADDR_W must be 6 or 8");
      end
      if (HI_CYC < 1 || LO_CYC < 1) begin : g_bad_phase
         $error("mw_burst_reader: serial clock phases must be at least one cycle");
      end
      if (HI_CYC + LO_CYC < CS_CYC) begin : g_bad_setup
         $error("mw_burst_reader: one serial period is shorter than the select setup");
      end
      if (USE_RDY && RDY_POLLS < 1) begin : g_bad_polls
         $error("mw_burst_reader: RDY_POLLS must be positive");
      end
   endgenerate

   logic run;
   logic high;
   logic phase_end;
   logic sample;
   logic last;

   mw_phase_timer #(
      .LO_CYC    (LO_CYC),
      .HI_CYC    (HI_CYC),
      .USE_RDY   (USE_RDY),
      .RDY_POLLS (RDY_POLLS)
   ) u_timer (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run),
      .high_i      (high),
      .rdy_i       (ee_rdy_i),
      .phase_end_o (phase_end)
   );

   mw_seq #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .go_i        (go_i),
      .start_i     (start_addr_i),
      .count_i     (word_count_i),
      .phase_end_i (phase_end),
      .run_o       (run),
      .high_o      (high),
      .cs_o        (ee_cs_o),
      .sk_o        (ee_sk_o),
      .do_o        (ee_do_o),
      .sample_o    (sample),
      .last_o      (last),
      .done_o      (done_o)
   );

   mw_rx_shift u_rx (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (sample),
      .last_i   (last),
      .di_i     (ee_di_i),
      .valid_o  (word_valid_o),
      .data_o   (word_data_o)
   );

endmodule

// File: rtl/mw_burst_reader_chk.sv
module mw_burst_reader_chk #(
   parameter int HI_CYC = 38,
   parameter int EXTRA  = 0
) (
   input logic clk_i,
   input logic rst_ni,
   input logic cs_i,
   input logic sk_i,
   input logic do_i,
   input logic valid_i,
   input logic done_i
);

   logic [31:0] hi_len_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hi_len_q <= '0;
      end else if (sk_i) begin
         hi_len_q <= hi_len_q + 32'd1;
      end else begin
         hi_len_q <= '0;
      end
   end

   a_r1_cs_rise_clock_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cs_i) |-> (!sk_i && !do_i));

   a_r5_high_min_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sk_i) |-> (hi_len_q >= 32'(HI_CYC)));

   a_r6_high_max_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sk_i) |-> (hi_len_q <= 32'(HI_CYC + EXTRA)));

   a_r7_pins_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sk_i && $past(sk_i)) |-> ($stable(do_i) && $stable(cs_i)));

   a_r10_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> !valid_i);

   a_r10_valid_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |-> (cs_i && sk_i));

   a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |=> !done_i);

   a_r11_done_pins_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> (!cs_i && !sk_i));

endmodule

bind mw_burst_reader mw_burst_reader_chk #(
   .HI_CYC (HI_CYC),
   .EXTRA  (USE_RDY ? RDY_POLLS : 0)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .cs_i    (ee_cs_o),
   .sk_i    (ee_sk_o),
   .do_i    (ee_do_o),
   .valid_i (word_valid_o),
   .done_i  (done_o)
);

// File: tb/mw_burst_reader_test.sv
module mw_burst_reader_test;

   localparam int A     = 6;
   localparam int HI    = 5;   // ceil(100 ns / 20 ns)
   localparam int LO    = 2;   // ceil(40 ns / 20 ns)
   localparam int POLLS = 6;
   localparam int SLOTS = 22 + A;
   localparam int NW    = 1 << A;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          go = 1'b0;
   logic [A-1:0]  start = '0;
   logic [A:0]    cnt = '0;
   logic          word_valid;
   logic [15:0]   word_data;
   logic          done;
   logic          ee_cs, ee_sk, ee_do;
   logic          ee_di = 1'b1;
   logic          ee_rdy = 1'b1;

   mw_burst_reader #(
      .ADDR_W        (A),
      .CLK_PERIOD_PS (20000),
      .SK_HIGH_NS    (100),
      .SK_LOW_NS     (40),
      .CS_SETUP_NS   (140),
      .USE_RDY       (1'b1),
      .RDY_POLLS     (POLLS)
   ) uut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .go_i         (go),
      .start_addr_i (start),
      .word_count_i (cnt),
      .word_valid_o (word_valid),
      .word_data_o  (word_data),
      .done_o       (done),
      .ee_cs_o      (ee_cs),
      .ee_sk_o      (ee_sk),
      .ee_do_o      (ee_do),
      .ee_di_i      (ee_di),
      .ee_rdy_i     (ee_rdy)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int n_valid = 0;
   int n_done = 0;
   int pin_act = 0;
   int cycles = 0;
   int rdy_mode = 0;
   logic [7:0] lfsr = 8'h5B;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int mem_word(input int a);
      return ((a * 40503) ^ 16'hA5C3 ^ (a << 9)) & 16'hFFFF;
   endfunction

   // reference model state
   bit m_run = 0, m_high = 0, e_valid = 0, e_done = 0;
   int m_slot = 0, m_cnt = 0, m_addr = 0, m_left = 0;
   // inputs seen by the design at the next rising edge
   bit p_rst = 0, p_go = 0, p_rdy = 1, p_di = 1;
   int p_start = 0, p_cnt = 0;
   // memory device model
   int d_edges = 0, d_addr = 0;
   int d_sh = 0;
   bit d_skp = 0;
   bit have_prev = 0;
   logic prev_sk = 0, prev_do = 0, prev_cs = 0;

   function automatic bit exp_do();
      if (!m_run) return 1'b0;
      if (m_slot == 1 || m_slot == 2) return 1'b1;
      if (m_slot >= 4 && m_slot < 4 + A) return bit'((m_addr >> (A - 1 - (m_slot - 4))) & 1);
      return 1'b0;
   endfunction

   always @(negedge clk) begin
      int lim;
      bit x_cs, x_sk, x_do;
      // model the rising edge that just happened
      e_valid = 0;
      e_done  = 0;
      if (!p_rst) begin
         m_run = 0; m_high = 0; m_slot = 0; m_cnt = 0;
      end else if (!m_run) begin
         if (p_go) begin
            if (p_cnt == 0) e_done = 1;
            else begin
               m_run = 1; m_slot = 0; m_high = 0; m_cnt = 0;
               m_addr = p_start; m_left = p_cnt;
            end
         end
      end else begin
         lim = m_high ? HI : LO;
         if (m_cnt >= lim - 1 && (p_rdy || m_cnt >= lim - 1 + POLLS)) begin
            if (!m_high && m_slot == 20 + A) e_valid = 1;
            if (m_high) begin
               if (m_slot == SLOTS - 1) begin
                  m_slot = 0;
                  if (m_left == 1) begin m_run = 0; e_done = 1; end
                  else begin m_left--; m_addr = (m_addr + 1) % NW; end
               end else m_slot++;
            end
            m_high = !m_high;
            m_cnt = 0;
         end else m_cnt++;
      end

      if (rst_n && p_rst) begin
         x_cs = m_run && (m_slot != SLOTS - 1);
         x_sk = m_run && m_high;
         x_do = exp_do();
         chk(ee_cs === x_cs, "R1 R4", "chip select", ee_cs, x_cs);
         chk(ee_sk === x_sk, "R5 R6", "serial clock", ee_sk, x_sk);
         chk(ee_do === x_do, "R2", "data out", ee_do, x_do);
         chk(word_valid === e_valid, "R10", "word valid", word_valid, e_valid);
         if (e_valid)
            chk(word_data === 16'(mem_word(m_addr)), "R3", "word data", word_data, mem_word(m_addr));
         chk(done === e_done, "R11", "done", done, e_done);
         if (have_prev && prev_sk && ee_sk)
            chk(ee_do === prev_do && ee_cs === prev_cs, "R7", "pins moved in high phase",
                {ee_cs, ee_do}, {prev_cs, prev_do});
         have_prev = 1;
      end else have_prev = 0;
      prev_sk = ee_sk; prev_do = ee_do; prev_cs = ee_cs;
      if (word_valid) n_valid++;
      if (done) n_done++;
      if (ee_cs || ee_sk || ee_do) pin_act++;

      // memory device: reacts to observed serial clock rises
      if (!ee_cs) begin
         d_edges = 0; d_sh = 0; ee_di = 1'b1;
      end else if (ee_sk && !d_skp) begin
         d_edges++;
         if (d_edges <= 4 + A) d_sh = (d_sh << 1) | int'(ee_do);
         if (d_edges == 4 + A) begin
            chk(((d_sh >> A) & 15) == 4'b0110, "R2", "select+command bits", (d_sh >> A) & 15, 6);
            d_addr = d_sh & (NW - 1);
            chk(d_addr == m_addr, "R4", "word address", d_addr, m_addr);
            ee_di = 1'b0;
         end else if (d_edges > 4 + A && d_edges <= 20 + A) begin
            ee_di = 1'(mem_word(d_addr) >> (15 - (d_edges - 5 - A)));
         end else ee_di = 1'b1;
      end
      d_skp = ee_sk;

      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ee_rdy = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (lfsr[0] | lfsr[2]) : 1'b0;

      p_rst = rst_n; p_go = go; p_start = start; p_cnt = cnt;
      p_rdy = ee_rdy; p_di = ee_di;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_bad++;
         $display("FAIL R11 watchdog: run never finished, got 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic pulse_go(input int s, input int c);
      @(posedge clk); #4;
      go = 1'b1; start = A'(s); cnt = (A+1)'(c);
      @(posedge clk); #4;
      go = 1'b0;
   endtask

   task automatic burst(input int s, input int c, input string tag);
      int v0, d0;
      v0 = n_valid; d0 = n_done;
      pulse_go(s, c);
      while (n_done == d0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(n_valid - v0 == c, tag, "words delivered", n_valid - v0, c);
      chk(n_done - d0 == 1, tag, "done pulses", n_done - d0, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R12: reset state
      chk(ee_cs === 1'b0 && ee_sk === 1'b0 && ee_do === 1'b0, "R12", "pins in reset",
          {ee_cs, ee_sk, ee_do}, 0);
      chk(word_valid === 1'b0 && done === 1'b0, "R12", "strobes in reset",
          {word_valid, done}, 0);
      @(posedge clk); #4; rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(ee_cs === 1'b0 && ee_sk === 1'b0, "R12", "pins after reset", {ee_cs, ee_sk}, 0);

      rdy_mode = 0;
      burst(5, 3, "R4");
      burst(62, 4, "R4");   // address wrap 62, 63, 0, 1

      begin : zero_count  // R9
         int p0, d0, v0;
         p0 = pin_act; d0 = n_done; v0 = n_valid;
         pulse_go(3, 0);
         repeat (4) @(negedge clk);
         chk(n_done - d0 == 1, "R9", "done on empty burst", n_done - d0, 1);
         chk(pin_act == p0, "R9", "serial pins touched", pin_act - p0, 0);
         chk(n_valid == v0, "R9", "words on empty burst", n_valid - v0, 0);
      end

      begin : go_while_busy  // R8
         int v0, d0;
         v0 = n_valid; d0 = n_done;
         pulse_go(20, 3);
         repeat (60) @(negedge clk);
         pulse_go(40, 5);
         while (n_done == d0) @(negedge clk);
         repeat (3) @(negedge clk);
         chk(n_valid - v0 == 3, "R8", "words after ignored go", n_valid - v0, 3);
         chk(n_done - d0 == 1, "R8", "done after ignored go", n_done - d0, 1);
      end

      rdy_mode = 1;
      burst(17, 5, "R6");
      rdy_mode = 2;
      burst(7, 2, "R6");
      rdy_mode = 0;
      burst(10, 64, "R4");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule